// File: doc/BRIEF.md
# Reloadable Overflow Event Timer

This block produces timed events for an operating-system tick. A 32-bit counter runs upward, one step per clock, and flags an event when it wraps from all-ones back to zero. To get an event a given number of ticks after start, software programs the counter with all-ones minus that number. With the reload option on, every wrap reloads the counter from a separate load register, so the tick repeats on its own. With reload off, the timer runs once and then stops itself.

The run control, load and counter registers take posted writes. Each accepted write spends a fixed resynchronisation interval in flight before it takes effect, and a pending flag is high for that whole interval. One further write can wait behind the one in flight. The status and interrupt-enable registers are written at once. Reads are combinational and return live values.

Register map (3-bit address): 0 control (bit 0 run, bit 1 reload), 1 load, 2 counter, 3 status (bit 0 overflow, write one to clear), 4 interrupt enable (bit 0), 5 write pending (bit 0). Any other address reads as zero.

Top module: `evtmr_top`

## Requirements
- R1: After reset the counter, load, control, status and enable registers read zero, and `irq` and `busy` are low.
- R2: A write to address 0, 1 or 2 that is accepted at clock edge W takes effect at edge W+3. Until then the register reads its old value. `busy` is high after edges W, W+1 and W+2 and low after W+3 if nothing else is queued.
- R3: A posted write that arrives while `busy` is high is held. It takes effect 3 edges after the earlier write takes effect, and `busy` stays high without a break until then.
- R4: While the run bit is set, the counter rises by one every clock, and a read of address 2 returns the current value.
- R5: When the counter is all-ones with the run bit set, status bit 0 is set at the next edge. A start at commit edge C from the value 0xFFFFFFFF-N sets status at edge C+N+1.
- R6: With the reload bit set, every wrap loads the counter from the load register. A load value of 0xFFFFFFFF-P therefore gives an event every P+1 cycles.
- R7: With the reload bit clear, a wrap clears the run bit and leaves the counter at 0, where it stays.
- R8: Writing status with bit 0 set clears the overflow flag. Writing it with bit 0 clear has no effect. If an overflow occurs in the same cycle as the clear, the flag stays set.
- R9: `irq` is high exactly while the overflow flag and the enable bit are both set.
- R10: Once a committed control write clears the run bit, the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 32 | Read data (combinational) |
| irq | output | 1 | Level interrupt |
| busy | output | 1 | A posted write is in flight |

## Verification
A counter wrap and a software clear of the status flag can fall on the same clock edge. The bench provokes this by starting a one-shot run whose wrap edge is known exactly, then placing the clear so it is sampled on that same edge. The result is judged by reading status after that edge, which must still be set, and by the interrupt scoreboard, which must see the rise at that edge. A second collision is a posted write that lands while another is still in flight. The bench checks it through the register contents and the `busy` flag on both sides of the later commit edge.

// File: rtl/evtmr_pkg.sv
package evtmr_pkg;
    localparam int CNT_W  = 32;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] A_LOAD  = 3'd1;
    localparam logic [ADDR_W-1:0] A_COUNT = 3'd2;
    localparam logic [ADDR_W-1:0] A_STAT  = 3'd3;
    localparam logic [ADDR_W-1:0] A_IEN   = 3'd4;
    localparam logic [ADDR_W-1:0] A_PEND  = 3'd5;

    localparam logic [CNT_W-1:0] CNT_ONES = '1;

    typedef enum logic [1:0] {
        PR_CTRL  = 2'd0,
        PR_LOAD  = 2'd1,
        PR_COUNT = 2'd2
    } preg_e;

    typedef struct packed {
        logic             vld;
        preg_e            sel;
        logic [CNT_W-1:0] data;
    } post_req_t;

    function automatic logic is_posted(input logic [ADDR_W-1:0] a);
        return (a == A_CTRL) || (a == A_LOAD) || (a == A_COUNT);
    endfunction

    function automatic preg_e addr_to_sel(input logic [ADDR_W-1:0] a);
        case (a)
            A_LOAD:  return PR_LOAD;
            A_COUNT: return PR_COUNT;
            default: return PR_CTRL;
        endcase
    endfunction
endpackage

// File: rtl/evtmr_post.sv
module evtmr_post
    import evtmr_pkg::*;
#(
    parameter int POST_DLY = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic              commit_vld,
    output post_req_t         commit_req,
    output logic              busy
);
    localparam int CW = $clog2(POST_DLY) + 1;
    localparam logic [CW-1:0] CNT_START = CW'(POST_DLY - 1);

    post_req_t     cur_q, hold_q, in_req;
    logic [CW-1:0] cnt_q;

    always_comb begin
        in_req.vld  = wr_en && is_posted(wr_addr);
        in_req.sel  = addr_to_sel(wr_addr);
        in_req.data = wr_data;
    end

    assign commit_vld = cur_q.vld && (cnt_q == '0);
    assign commit_req = cur_q;
    assign busy       = cur_q.vld;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q  <= '0;
            hold_q <= '0;
            cnt_q  <= '0;
        end else if (cur_q.vld) begin
            if (cnt_q == '0) begin
                if (hold_q.vld) begin
                    cur_q  <= hold_q;
                    cnt_q  <= CNT_START;
                    hold_q <= in_req;
                end else if (in_req.vld) begin
                    cur_q <= in_req;
                    cnt_q <= CNT_START;
                end else begin
                    cur_q.vld <= 1'b0;
                end
            end else begin
                cnt_q <= cnt_q - 1'b1;
                if (in_req.vld) begin
                    hold_q <= in_req;
                end
            end
        end else if (in_req.vld) begin
            cur_q <= in_req;
            cnt_q <= CNT_START;
        end
    end

    // R2
    commit_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
        commit_vld |-> $past(busy));

    // R3
    hold_keeps_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (hold_q.vld && !commit_vld) |=> busy);
endmodule

// File: rtl/evtmr_counter.sv
module evtmr_counter
    import evtmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             commit_vld,
    input  post_req_t        commit_req,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] load,
    output logic             run,
    output logic             reload,
    output logic             ovf_evt
);
    assign ovf_evt = run && (count == CNT_ONES);

    always_ff @(posedge clk) begin
        if (rst) begin
            count  <= '0;
            load   <= '0;
            run    <= 1'b0;
            reload <= 1'b0;
        end else begin
            if (run) begin
                if (count == CNT_ONES) begin
                    if (reload) begin
                        count <= load;
                    end else begin
                        count <= '0;
                        run   <= 1'b0;
                    end
                end else begin
                    count <= count + 1'b1;
                end
            end
            if (commit_vld) begin
                case (commit_req.sel)
                    PR_CTRL: begin
                        run    <= commit_req.data[0];
                        reload <= commit_req.data[1];
                    end
                    PR_LOAD:  load  <= commit_req.data;
                    PR_COUNT: count <= commit_req.data;
                    default: ;
                endcase
            end
        end
    end

    // R4
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (run && !commit_vld && count != CNT_ONES) |=> (count == $past(count) + 1'b1));

    // R10
    stopped_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!run && !commit_vld) |=> $stable(count));

    // R7
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (ovf_evt && !reload && !commit_vld) |=> (!run && count == '0));
endmodule

// File: rtl/evtmr_stat.sv
module evtmr_stat (
    input  logic clk,
    input  logic rst,
    input  logic ovf_evt,
    input  logic clr_req,
    input  logic ien_wr,
    input  logic ien_val,
    output logic status,
    output logic ien,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            status <= 1'b0;
            ien    <= 1'b0;
        end else begin
            if (ovf_evt) begin
                status <= 1'b1;
            end else if (clr_req) begin
                status <= 1'b0;
            end
            if (ien_wr) begin
                ien <= ien_val;
            end
        end
    end

    assign irq = status && ien;

    // R5
    ovf_sets_chk: assert property (@(posedge clk) disable iff (rst)
        ovf_evt |=> status);

    // R8
    w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_req && !ovf_evt) |=> !status);
endmodule

// File: rtl/evtmr_top.sv
module evtmr_top
    import evtmr_pkg::*;
#(
    parameter int POST_DLY = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    output logic              irq,
    output logic              busy
);
    logic             commit_vld;
    post_req_t        commit_req;
    logic [CNT_W-1:0] count, load;
    logic             run, reload, ovf_evt;
    logic             status, ien;
    logic             clr_req, ien_wr;

    assign clr_req = wr_en && (wr_addr == A_STAT) && wr_data[0];
    assign ien_wr  = wr_en && (wr_addr == A_IEN);

    evtmr_post #(.POST_DLY(POST_DLY)) u_post (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .commit_vld (commit_vld),
        .commit_req (commit_req),
        .busy       (busy)
    );

    evtmr_counter u_cnt (
        .clk        (clk),
        .rst        (rst),
        .commit_vld (commit_vld),
        .commit_req (commit_req),
        .count      (count),
        .load       (load),
        .run        (run),
        .reload     (reload),
        .ovf_evt    (ovf_evt)
    );

    evtmr_stat u_stat (
        .clk     (clk),
        .rst     (rst),
        .ovf_evt (ovf_evt),
        .clr_req (clr_req),
        .ien_wr  (ien_wr),
        .ien_val (wr_data[0]),
        .status  (status),
        .ien     (ien),
        .irq     (irq)
    );

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_CTRL:  rd_data[1:0] = {reload, run};
            A_LOAD:  rd_data      = load;
            A_COUNT: rd_data      = count;
            A_STAT:  rd_data[0]   = status;
            A_IEN:   rd_data[0]   = ien;
            A_PEND:  rd_data[0]   = busy;
            default: rd_data      = '0;
        endcase
    end
endmodule

// File: tb/sim_evtmr_top.sv
`timescale 1ns/1ps
module sim_evtmr_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq, busy;

    int checks = 0;
    int fails  = 0;
    int edge_cnt = 0;
    int exp_q[$];
    logic irq_q = 1'b0;
    bit done = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) edge_cnt <= edge_cnt + 1;

    evtmr_top u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .irq(irq), .busy(busy)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic wait_edge(input int e);
        while (edge_cnt < e) @(negedge clk);
    endtask

    // posted write: waits for idle, returns the commit edge
    task automatic post_wr(input logic [2:0] a, input logic [31:0] d, output int ce);
        while (busy) @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        ce = edge_cnt + 1 + 3;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic imm_wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // scoreboard monitor: irq rising edges against expected edge numbers
    always @(negedge clk) begin
        if (!rst && irq && !irq_q) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R9 unexpected irq rise actual=%0d expected=none", edge_cnt);
            end else begin
                int e;
                e = exp_q.pop_front();
                if (e != edge_cnt) begin
                    fails++;
                    $display("FAIL R5 irq rise edge actual=%0d expected=%0d", edge_cnt, e);
                end
            end
        end
        irq_q <= irq;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int c, c2, w, cw;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(3'd2, v); chk("R1 count", v, 0);
        rd(3'd1, v); chk("R1 load", v, 0);
        rd(3'd0, v); chk("R1 ctrl", v, 0);
        rd(3'd3, v); chk("R1 status", v, 0);
        rd(3'd4, v); chk("R1 ien", v, 0);
        chk("R1 irq", {31'd0, irq}, 0);
        chk("R1 busy", {31'd0, busy}, 0);

        // R2 posted latency
        post_wr(3'd1, 32'h1234, c);
        w = c - 3;
        wait_edge(w);     chk("R2 busy after accept", {31'd0, busy}, 1);
        wait_edge(c - 1); rd(3'd1, v); chk("R2 load old", v, 0);
        chk("R2 busy before commit", {31'd0, busy}, 1);
        wait_edge(c);     rd(3'd1, v); chk("R2 load new", v, 32'h1234);
        chk("R2 busy clear", {31'd0, busy}, 0);

        // R3 held write behind one in flight
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd2; wr_data = 32'h50; w = edge_cnt + 1;
        @(negedge clk);
        wr_addr = 3'd1; wr_data = 32'h77;
        @(negedge clk);
        wr_en = 1'b0;
        wait_edge(w + 3); rd(3'd2, v); chk("R3 first commit", v, 32'h50);
        wait_edge(w + 5); rd(3'd1, v); chk("R3 held not yet", v, 32'h1234);
        chk("R3 busy continuous", {31'd0, busy}, 1);
        wait_edge(w + 6); rd(3'd1, v); chk("R3 held commit", v, 32'h77);
        chk("R3 busy clear", {31'd0, busy}, 0);

        // R4 live count, R10 stop holds
        post_wr(3'd2, 32'd1000, c);
        post_wr(3'd0, 32'h1, c);
        wait_edge(c + 5); rd(3'd2, v); chk("R4 count live", v, 1005);
        wait_edge(c + 9); rd(3'd2, v); chk("R4 count live later", v, 1009);
        post_wr(3'd0, 32'h0, cw);
        wait_edge(cw); rd(3'd2, v); chk("R10 count at stop", v, 1000 + (cw - c));
        wait_edge(cw + 4); rd(3'd2, v); chk("R10 count held", v, 1000 + (cw - c));

        // R5/R7 one-shot with interrupt enabled
        imm_wr(3'd4, 32'h1);
        post_wr(3'd2, 32'hFFFFFFFF - 20, c2);
        post_wr(3'd0, 32'h1, c);
        exp_q.push_back(c + 21);
        wait_edge(c + 20); rd(3'd3, v); chk("R5 status before wrap", v, 0);
        wait_edge(c + 21); rd(3'd3, v); chk("R5 status on wrap", v, 1);
        rd(3'd0, v); chk("R7 run cleared", v, 0);
        rd(3'd2, v); chk("R7 count zero", v, 0);
        wait_edge(c + 25); rd(3'd2, v); chk("R7 count stays", v, 0);
        imm_wr(3'd3, 32'h0); rd(3'd3, v); chk("R8 write zero ignored", v, 1);
        imm_wr(3'd3, 32'h1); rd(3'd3, v); chk("R8 w1c clears", v, 0);
        chk("R9 irq low after clear", {31'd0, irq}, 0);

        // R9 enable gating
        imm_wr(3'd4, 32'h0);
        post_wr(3'd2, 32'hFFFFFFFF - 5, c2);
        post_wr(3'd0, 32'h1, c);
        wait_edge(c + 7); rd(3'd3, v); chk("R9 status set", v, 1);
        chk("R9 irq masked", {31'd0, irq}, 0);
        exp_q.push_back(edge_cnt + 1);
        imm_wr(3'd4, 32'h1);
        chk("R9 irq on enable", {31'd0, irq}, 1);
        imm_wr(3'd3, 32'h1);

        // R8 wrap and clear on the same edge
        post_wr(3'd2, 32'hFFFFFFFF - 10, c2);
        post_wr(3'd0, 32'h1, c);
        exp_q.push_back(c + 11);
        wait_edge(c + 10);
        imm_wr(3'd3, 32'h1);
        rd(3'd3, v); chk("R8 set wins over clear", v, 1);
        chk("R9 irq high", {31'd0, irq}, 1);
        imm_wr(3'd3, 32'h1);

        // R6 periodic reload, period 12
        post_wr(3'd1, 32'hFFFFFFFF - 11, c2);
        post_wr(3'd2, 32'hFFFFFFFF - 11, c2);
        post_wr(3'd0, 32'h3, c);
        for (int i = 1; i <= 3; i++) exp_q.push_back(c + 12 * i);
        for (int i = 1; i <= 3; i++) begin
            wait_edge(c + 12 * i);
            rd(3'd2, v); chk("R6 reloaded count", v, 32'hFFFFFFFF - 11);
            rd(3'd3, v); chk("R6 status each period", v, 1);
            imm_wr(3'd3, 32'h1);
        end
        post_wr(3'd0, 32'h0, cw);
        wait_edge(cw + 2);

        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R5 missing irq rises actual=%0d expected=0", exp_q.size());
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule